// File: doc/BRIEF.md
# Write Busy Status Reporter

This block sits in the read path of a memory emulator. A write controller runs an internal programming period and raises a busy flag for its whole length. During that period the host cannot yet see the new contents, so it reads the device to learn when programming has ended. This multiplexer sits between the array read data and the host read bus. While busy is high it replaces part of each returned byte with two status indicators. Once busy falls, it passes the stored data through unchanged.

There are two indicators, and the host may use either one. On bit 7 the block returns the inverse of bit 7 of the byte last written, but only when the read address equals that byte's address. On bit 6 it returns a flag that flips at every new read cycle during busy. A read cycle begins when the read condition becomes true. It can be restarted by raising and lowering either chip enable or output enable, or both. The host may begin status reads at any time during the busy period. The toggle flag is not forced to a known value when a write starts; it keeps whatever value the previous busy period left.

Reads are modelled synchronously. The strobes are sampled on a clock edge, and the registered read word and its valid flag appear after that same edge. A low valid flag stands for the high-impedance bus.

Top module: `wr_busy_status`

## Requirements
- R1: A read is sampled in a cycle where `ce_n`=0, `oe_n`=0 and `we_n`=1. `rd_valid_o` is 1 in the cycle after such a cycle and 0 in the cycle after any other cycle.
- R2: Whenever `rd_valid_o` is 0, `rd_data_o` is 8'h00.
- R3: In a read sampled with `busy_i`=1 and `rd_addr_i` equal to `last_addr_i`, bit 7 of `rd_data_o` is the inverse of `last_data_i[7]`.
- R4: In a read sampled with `busy_i`=1, bits 5..0 of `rd_data_o` equal `array_data_i[5:0]`. If `rd_addr_i` differs from `last_addr_i`, bit 7 equals `array_data_i[7]`.
- R5: During busy, the first sampled cycle of each new read cycle inverts the toggle flag, and bit 6 shows the new flag value. Later cycles of the same read cycle show the same bit 6.
- R6: In a read sampled with `busy_i`=0, `rd_data_o` equals `array_data_i` on all 8 bits. This includes the very cycle in which `busy_i` first returns to 0.
- R7: The toggle flag advances only at the start of a read cycle sampled with `busy_i`=1. Reads while not busy leave it unchanged. It carries across busy periods without being reinitialised.
- R8: Reset (`rst_n`=0) clears `rd_valid_o`, `rd_data_o` and the toggle flag. The first busy read after reset therefore returns bit 6 = 1.
- R9: A cycle with `ce_n`=0, `oe_n`=0 and `we_n`=0 is not a read. It produces `rd_valid_o`=0 and does not advance the toggle flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| rd_addr_i | input | AW (15) | Read address |
| busy_i | input | 1 | Internal write in progress |
| last_addr_i | input | AW (15) | Address of the last written byte |
| last_data_i | input | DW (8) | Value of the last written byte |
| array_data_i | input | DW (8) | Array contents at `rd_addr_i` |
| rd_valid_o | output | 1 | Read bus driven (low models high impedance) |
| rd_data_o | output | DW (8) | Read word |

## Verification
Every result is due one clock edge after the cycle whose inputs produced it. The inputs include the strobes, busy, the addresses and the array word. The toggle flag changes at that same edge, so the bit 6 value of a read appears together with the rest of its word. The bench changes inputs on the falling edge, lets one rising edge pass, and samples shortly after it. In this way every expected word pairs with exactly the input cycle that produced it. The expected toggle values are followed by hand through the vector table, counting only busy read starts.

// File: rtl/wbs_pkg.sv
package wbs_pkg;
  localparam int unsigned WBS_DW = 8;

  typedef struct packed {
    logic ce_n;
    logic oe_n;
    logic we_n;
  } strobe_t;

  function automatic logic is_read(input strobe_t s);
    return (!s.ce_n) && (!s.oe_n) && s.we_n;
  endfunction
endpackage

// File: rtl/wbs_read_detect.sv
module wbs_read_detect
  import wbs_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  strobe_t strb,
  output logic    rd_now,
  output logic    rd_start
);
  logic rd_prev_q;

  assign rd_now   = is_read(strb);
  assign rd_start = rd_now && !rd_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_prev_q <= 1'b0;
    else        rd_prev_q <= rd_now;
  end
endmodule

// File: rtl/wbs_toggle.sv
module wbs_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic advance,
  output logic flag_next
);
  logic flag_q;

  assign flag_next = advance ? ~flag_q : flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_next;
  end
endmodule

// File: rtl/wbs_status_mux.sv
module wbs_status_mux #(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_now,
  input  logic          busy,
  input  logic [AW-1:0] rd_addr,
  input  logic [AW-1:0] last_addr,
  input  logic [DW-1:0] last_data,
  input  logic [DW-1:0] array_data,
  input  logic          flag,
  output logic          valid_q,
  output logic [DW-1:0] data_q
);
  localparam int unsigned POLL_BIT = DW - 1;
  localparam int unsigned TGL_BIT  = DW - 2;

  logic          hit;
  logic [DW-1:0] word;

  assign hit = busy && (rd_addr == last_addr);

  for (genvar i = 0; i < DW; i++) begin : g_bit
    if (i == POLL_BIT) begin : g_poll
      assign word[i] = hit ? ~last_data[i] : array_data[i];
    end else if (i == TGL_BIT) begin : g_tgl
      assign word[i] = busy ? flag : array_data[i];
    end else begin : g_pass
      assign word[i] = array_data[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= rd_now;
      data_q  <= rd_now ? word : '0;
    end
  end
endmodule

// File: rtl/wr_busy_status.sv
module wr_busy_status
  import wbs_pkg::*;
#(
  parameter int unsigned AW = 15,
  parameter int unsigned DW = WBS_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] rd_addr_i,
  input  logic          busy_i,
  input  logic [AW-1:0] last_addr_i,
  input  logic [DW-1:0] last_data_i,
  input  logic [DW-1:0] array_data_i,
  output logic          rd_valid_o,
  output logic [DW-1:0] rd_data_o
);
  strobe_t strb;
  logic    rd_now;
  logic    rd_start;
  logic    flag_next;

  assign strb = '{ce_n: ce_n, oe_n: oe_n, we_n: we_n};

  wbs_read_detect u_detect (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .rd_now   (rd_now),
    .rd_start (rd_start)
  );

  wbs_toggle u_toggle (
    .clk       (clk),
    .rst_n     (rst_n),
    .advance   (rd_start && busy_i),
    .flag_next (flag_next)
  );

  wbs_status_mux #(.DW(DW), .AW(AW)) u_mux (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_now     (rd_now),
    .busy       (busy_i),
    .rd_addr    (rd_addr_i),
    .last_addr  (last_addr_i),
    .last_data  (last_data_i),
    .array_data (array_data_i),
    .flag       (flag_next),
    .valid_q    (rd_valid_o),
    .data_q     (rd_data_o)
  );
endmodule

// File: rtl/wr_busy_status_chk.sv
module wr_busy_status_chk #(
  parameter int unsigned AW = 15,
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce_n,
  input logic          oe_n,
  input logic          we_n,
  input logic [AW-1:0] rd_addr_i,
  input logic          busy_i,
  input logic [AW-1:0] last_addr_i,
  input logic [DW-1:0] last_data_i,
  input logic [DW-1:0] array_data_i,
  input logic          rd_valid_o,
  input logic [DW-1:0] rd_data_o
);
  logic rd_c;
  logic rd_c_q;
  logic bstart_q;
  logic seen_q;
  logic last_b6_q;

  assign rd_c = !ce_n && !oe_n && we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_c_q    <= 1'b0;
      bstart_q  <= 1'b0;
      seen_q    <= 1'b0;
      last_b6_q <= 1'b0;
    end else begin
      rd_c_q   <= rd_c;
      bstart_q <= rd_c && !rd_c_q && busy_i;
      if (bstart_q) begin
        seen_q    <= 1'b1;
        last_b6_q <= rd_data_o[DW-2];
      end
    end
  end

  p_read_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_c |=> rd_valid_o);
  p_noread_invalid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_c |=> !rd_valid_o);
  p_idle_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid_o |-> rd_data_o == '0);
  p_poll_inv_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_c && busy_i && rd_addr_i == last_addr_i)
      |=> rd_data_o[DW-1] == ~$past(last_data_i[DW-1]));
  p_low_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_c && busy_i) |=> rd_data_o[DW-3:0] == $past(array_data_i[DW-3:0]));
  p_true_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_c && !busy_i) |=> rd_data_o == $past(array_data_i));
  p_toggle_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bstart_q && seen_q) |-> rd_data_o[DW-2] != last_b6_q);
  p_toggle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_c && rd_c_q && busy_i && $past(busy_i)) |=> $stable(rd_data_o[DW-2]));
endmodule

bind wr_busy_status wr_busy_status_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ce_n         (ce_n),
  .oe_n         (oe_n),
  .we_n         (we_n),
  .rd_addr_i    (rd_addr_i),
  .busy_i       (busy_i),
  .last_addr_i  (last_addr_i),
  .last_data_i  (last_data_i),
  .array_data_i (array_data_i),
  .rd_valid_o   (rd_valid_o),
  .rd_data_o    (rd_data_o)
);

// File: tb/wr_busy_status_tb.sv
module wr_busy_status_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 15;
  localparam int DW = 8;
  localparam logic [AW-1:0] LA = 15'h1234;

  typedef struct packed {
    logic          ce, oe, we, busy;
    logic [AW-1:0] addr;
    logic [DW-1:0] last, arr;
    logic          ev;
    logic [DW-1:0] ed;
  } vec_t;

  // Toggle flag traced by hand: reset 0, flips on every busy read start.
  localparam int NV = 14;
  localparam vec_t VEC [0:NV-1] = '{
    '{1'b1,1'b0,1'b1,1'b1, LA,       8'hA5,8'hFF, 1'b0,8'h00}, // idle  R1
    '{1'b0,1'b0,1'b1,1'b1, LA,       8'hA5,8'hFF, 1'b1,8'h7F}, // flag->1 R3 R5 R8
    '{1'b0,1'b0,1'b1,1'b1, LA,       8'hA5,8'hFF, 1'b1,8'h7F}, // same cycle R5
    '{1'b0,1'b1,1'b1,1'b1, LA,       8'hA5,8'hFF, 1'b0,8'h00}, // oe high R2
    '{1'b0,1'b0,1'b1,1'b1, 15'h0001, 8'hA5,8'hFF, 1'b1,8'hBF}, // flag->0 R4
    '{1'b1,1'b1,1'b1,1'b1, LA,       8'hA5,8'hFF, 1'b0,8'h00}, // idle
    '{1'b0,1'b0,1'b1,1'b1, LA,       8'hA5,8'hFF, 1'b1,8'h7F}, // flag->1 R5
    '{1'b1,1'b0,1'b1,1'b0, LA,       8'hA5,8'hFF, 1'b0,8'h00}, // idle
    '{1'b0,1'b0,1'b1,1'b0, LA,       8'hA5,8'hFF, 1'b1,8'hFF}, // not busy R6
    '{1'b1,1'b0,1'b1,1'b0, LA,       8'hA5,8'hFF, 1'b0,8'h00}, // idle
    '{1'b0,1'b0,1'b0,1'b1, LA,       8'h21,8'h5A, 1'b0,8'h00}, // we low R9
    '{1'b0,1'b0,1'b1,1'b1, LA,       8'h21,8'h5A, 1'b1,8'h9A}, // flag->0 R7 R3
    '{1'b1,1'b0,1'b1,1'b1, LA,       8'h21,8'h5A, 1'b0,8'h00}, // ce high
    '{1'b0,1'b0,1'b1,1'b1, 15'h0002, 8'h21,8'h00, 1'b1,8'h40}  // flag->1 R4 R5
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, busy_i = 1'b0;
  logic [AW-1:0] rd_addr_i = '0, last_addr_i = '0;
  logic [DW-1:0] last_data_i = '0, array_data_i = '0;
  logic          rd_valid_o;
  logic [DW-1:0] rd_data_o;
  int            n_chk = 0, n_bad = 0;
  bit            done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wr_busy_status #(.AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .rd_addr_i(rd_addr_i), .busy_i(busy_i), .last_addr_i(last_addr_i),
    .last_data_i(last_data_i), .array_data_i(array_data_i),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o)
  );

  task automatic check(input string req, input logic ev, input logic [DW-1:0] ed);
    n_chk++;
    if (rd_valid_o !== ev || rd_data_o !== ed) begin
      n_bad++;
      $display("FAIL %s: got valid=%0b data=%02h, want valid=%0b data=%02h",
               req, rd_valid_o, rd_data_o, ev, ed);
    end
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk);
    ce_n = v.ce; oe_n = v.oe; we_n = v.we; busy_i = v.busy;
    rd_addr_i = v.addr; last_addr_i = LA; last_data_i = v.last; array_data_i = v.arr;
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout, want completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R8 reset", 1'b0, 8'h00);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i]);
      check($sformatf("table vector %0d", i), VEC[i].ev, VEC[i].ed);
    end

    // R8: reset mid-run clears the flag; first busy read shows bit 6 = 1
    @(negedge clk) rst_n = 1'b0; ce_n = 1'b1;
    #1 check("R8 async clear", 1'b0, 8'h00);
    @(negedge clk) rst_n = 1'b1;
    apply('{1'b0,1'b0,1'b1,1'b1, 15'h0003, 8'h80, 8'h00, 1'b1, 8'h40});
    check("R8 flag after reset", 1'b1, 8'h40);

    // R6: continuous read, busy drops; that very cycle returns true data
    apply('{1'b0,1'b0,1'b1,1'b1, LA, 8'h80, 8'hC3, 1'b1, 8'h43});
    check("R3 R5 held read busy", 1'b1, 8'h43);
    apply('{1'b0,1'b0,1'b1,1'b0, LA, 8'h80, 8'hC3, 1'b1, 8'hC3});
    check("R6 busy clear cycle", 1'b1, 8'hC3);

    // R7: non-busy read starts leave the flag alone (still 1 -> next busy read 0)
    apply('{1'b1,1'b0,1'b1,1'b0, LA, 8'h80, 8'hC3, 1'b0, 8'h00});
    apply('{1'b0,1'b0,1'b1,1'b0, LA, 8'h80, 8'hC3, 1'b1, 8'hC3});
    check("R7 idle read", 1'b1, 8'hC3);
    apply('{1'b0,1'b1,1'b1,1'b1, LA, 8'h80, 8'hC3, 1'b0, 8'h00});
    apply('{1'b0,1'b0,1'b1,1'b1, 15'h0004, 8'h80, 8'h00, 1'b1, 8'h00});
    check("R7 carried flag", 1'b1, 8'h00);

    finish_run();
  end
endmodule